// File: doc/BRIEF.md
# Speculative Segmented Adder with Two-Way Error Compensation

This block is a combinational unsigned adder built for speed, not exactness. The operand width is cut into equal segments, and each segment adds on its own. Segments do not wait for the carry from below. Instead, every segment above the lowest one guesses its incoming carry from a short window of operand bits just under its boundary. The guess uses generate/propagate look-ahead. When every bit in the window propagates, the guess is 0. The lowest segment takes the real carry input, so it never guesses.

A compensation stage compares each guess with the carry-out of the segment below, as computed locally. Because a window that holds a generate or kill bit fixes that carry, the only possible miss is a carry that arrived but was guessed as 0. The stage handles a miss in one of two ways:

- **Correction:** if the low correction bits of the segment's local sum are not all ones, it increments the segment, which absorbs the carry exactly.
- **Reduction:** if those bits are all ones, the increment would overflow them. The segment is then left alone, and the top reduction bits of the segment below are forced to ones, which shrinks the arithmetic error.

Each segment's compensation is held in an action enum with three values:

| Action | Meaning |
|---|---|
| `CMP_NONE` | no miss |
| `CMP_CORRECT` | miss absorbed by increment |
| `CMP_REDUCE` | miss pushed down as a reduction of the segment below |

The block has no clock and no state, so there are no states or transitions. The enum is the whole decision. Width, path count, speculation width, correction width and reduction width are all parameters.

Top module: `isa_adder`

## Requirements
- R1: The result bits below position SEG-RED (SEG = WIDTH/NPATH) always equal the exact sum's bits, because the lowest segment uses the true carry input.
- R2: Each segment k≥1 adds with a guessed carry. The guess is the carry out of the SPEC operand bits directly below bit k·SEG with carry-in 0, so an all-propagate window gives 0. With SPEC=0 the guess is always 0.
- R3: When SPEC>0 and every speculation window holds at least one non-propagate bit, {carry_out, sum_out} equals the exact a+b+carry_in.
- R4: On a miss in segment k, where the carry-out of segment k-1 is 1 and the guess is 0, if the low COR bits of segment k's local sum are not all ones, segment k is output as its local sum plus 1.
- R5: On a miss whose low COR bits are all ones, or when COR=0, segment k is kept unchanged and the top RED bits of segment k-1 are set to ones.
- R6: carry_out is the local carry-out of the top segment. Compensation never changes it.
- R7: With opnd_b=0 and carry_in=0, sum_out equals opnd_a and carry_out is 0.
- R8: With COR=0 and RED=0, a missed carry is simply dropped, and each segment outputs its own local sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into the lowest segment |
| sum_out | output | WIDTH | Approximate sum |
| carry_out | output | 1 | Carry out of the top segment |

## Verification
The assertions take for granted a legal configuration: WIDTH divisible by NPATH, SPEC≤SEG, and COR+RED≤SEG with RED<SEG. They also assume the operands have settled when the combinational checks evaluate. The bench builds three instances with legal parameter sets only. It changes the inputs on the falling clock edge and samples one nanosecond after the rising edge. It mixes uniform vectors with propagate-heavy pairs (b near ~a), so that misses, corrections and reductions all occur often.

// File: rtl/isa_pkg.sv
package isa_pkg;
    typedef enum logic [1:0] {
        CMP_NONE    = 2'd0,
        CMP_CORRECT = 2'd1,
        CMP_REDUCE  = 2'd2
    } cmp_act_e;
endpackage

// File: rtl/isa_carry_guess.sv
module isa_carry_guess #(
    parameter int SPEC = 2
) (
    input  logic [SPEC-1:0] win_a,
    input  logic [SPEC-1:0] win_b,
    output logic            guess
);
    logic [SPEC-1:0] gen_bits;
    logic [SPEC-1:0] prp_bits;

    assign gen_bits = win_a & win_b;
    assign prp_bits = win_a ^ win_b;

    // look-ahead from the bottom of the window, carry-in assumed 0
    always_comb begin
        guess = 1'b0;
        for (int i = 0; i < SPEC; i++) begin
            guess = gen_bits[i] | (prp_bits[i] & guess);
        end
    end
endmodule

// File: rtl/isa_seg_add.sv
module isa_seg_add #(
    parameter int SEG = 8
) (
    input  logic [SEG-1:0] seg_a,
    input  logic [SEG-1:0] seg_b,
    input  logic           seg_ci,
    output logic [SEG-1:0] seg_s,
    output logic           seg_co
);
    assign {seg_co, seg_s} = {1'b0, seg_a} + {1'b0, seg_b} + {{SEG{1'b0}}, seg_ci};
endmodule

// File: rtl/isa_comp.sv
module isa_comp
    import isa_pkg::*;
#(
    parameter int SEG = 8,
    parameter int COR = 3
) (
    input  logic [SEG-1:0] loc_sum,
    input  logic           miss,
    output logic [SEG-1:0] fix_sum,
    output cmp_act_e       act
);
    logic cor_full;

    generate
        if (COR == 0) begin : g_nocor
            assign cor_full = 1'b1;
        end else begin : g_cor
            assign cor_full = &loc_sum[COR-1:0];
        end
    endgenerate

    always_comb begin
        if (!miss)         act = CMP_NONE;
        else if (!cor_full) act = CMP_CORRECT;
        else               act = CMP_REDUCE;
    end

    always_comb begin
        unique case (act)
            CMP_CORRECT: fix_sum = loc_sum + {{(SEG-1){1'b0}}, 1'b1};
            default:     fix_sum = loc_sum;
        endcase
    end
endmodule

// File: rtl/isa_adder.sv
module isa_adder
    import isa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NPATH = 4,
    parameter int SPEC  = 2,
    parameter int COR   = 3,
    parameter int RED   = 2
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int SEG = WIDTH / NPATH;
    localparam logic [SEG-1:0] RED_MASK = ~({SEG{1'b1}} >> RED);

    logic [SEG-1:0] loc_s [NPATH];
    logic [SEG-1:0] fix_s [NPATH];
    logic [NPATH-1:0] loc_co;
    logic [NPATH-1:0] guess;
    logic [NPATH-1:0] red_req;
    logic [NPATH-1:0] red_from_above;

    generate
        for (genvar k = 0; k < NPATH; k++) begin : g_seg
            if (k == 0) begin : g_base
                assign guess[k]   = carry_in;
                assign fix_s[k]   = loc_s[k];
                assign red_req[k] = 1'b0;
            end else begin : g_spec
                cmp_act_e act;
                logic     miss;
                if (SPEC > 0) begin : g_win
                    isa_carry_guess #(.SPEC(SPEC)) u_guess (
                        .win_a (opnd_a[k*SEG-1 -: SPEC]),
                        .win_b (opnd_b[k*SEG-1 -: SPEC]),
                        .guess (guess[k])
                    );
                end else begin : g_zero
                    assign guess[k] = 1'b0;
                end
                assign miss = loc_co[k-1] & ~guess[k];
                isa_comp #(.SEG(SEG), .COR(COR)) u_comp (
                    .loc_sum (loc_s[k]),
                    .miss    (miss),
                    .fix_sum (fix_s[k]),
                    .act     (act)
                );
                assign red_req[k] = (act == CMP_REDUCE);
            end

            isa_seg_add #(.SEG(SEG)) u_add (
                .seg_a  (opnd_a[k*SEG +: SEG]),
                .seg_b  (opnd_b[k*SEG +: SEG]),
                .seg_ci (guess[k]),
                .seg_s  (loc_s[k]),
                .seg_co (loc_co[k])
            );
        end
    endgenerate

    assign red_from_above = red_req >> 1;

    generate
        for (genvar k = 0; k < NPATH; k++) begin : g_out
            assign sum_out[k*SEG +: SEG] = fix_s[k] | (red_from_above[k] ? RED_MASK : '0);
        end
    endgenerate

    assign carry_out = loc_co[NPATH-1];
endmodule

// File: rtl/isa_adder_chk.sv
module isa_adder_chk #(
    parameter int WIDTH = 32,
    parameter int NPATH = 4,
    parameter int SPEC  = 2,
    parameter int COR   = 3,
    parameter int RED   = 2
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);
    localparam int SEG = WIDTH / NPATH;
    localparam logic [WIDTH-1:0] LOW_MASK = ~({WIDTH{1'b1}} << (SEG - RED));
    localparam logic [WIDTH-1:0] WIN_MASK = ~({WIDTH{1'b1}} << SPEC);

    logic [WIDTH:0]   exact;
    logic [WIDTH-1:0] prp;
    logic             decided;

    assign exact = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
    assign prp   = opnd_a ^ opnd_b;

    always_comb begin
        decided = (SPEC > 0);
        for (int k = 1; k < NPATH; k++) begin
            if (((prp >> (k*SEG - SPEC)) & WIN_MASK) == WIN_MASK) decided = 1'b0;
        end
    end

    always_comb begin
        assert_low_bits_exact_R1: assert (((sum_out ^ exact[WIDTH-1:0]) & LOW_MASK) == '0);
        if (decided) begin
            assert_exact_when_decided_R3: assert ({carry_out, sum_out} == exact);
            assert_cout_when_decided_R6: assert (carry_out == exact[WIDTH]);
        end
        if (opnd_b == '0 && !carry_in) begin
            assert_zero_addend_R7: assert (sum_out == opnd_a && !carry_out);
        end
    end
endmodule

bind isa_adder isa_adder_chk #(
    .WIDTH(WIDTH), .NPATH(NPATH), .SPEC(SPEC), .COR(COR), .RED(RED)
) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/isa_adder_bench.sv
module isa_adder_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] ta, tb;
    logic        tc;
    logic [31:0] s1, s2, s3;
    logic        c1, c2, c3;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    // config 1: 4 paths, spec 2, cor 3, red 2
    isa_adder #(.WIDTH(32), .NPATH(4), .SPEC(2), .COR(3), .RED(2)) u_isa_adder (
        .opnd_a(ta), .opnd_b(tb), .carry_in(tc), .sum_out(s1), .carry_out(c1));
    // config 2: 2 paths, spec 1, cor 2, red 4
    isa_adder #(.WIDTH(32), .NPATH(2), .SPEC(1), .COR(2), .RED(4)) u_isa_adder_c2 (
        .opnd_a(ta), .opnd_b(tb), .carry_in(tc), .sum_out(s2), .carry_out(c2));
    // config 3: 4 paths, no speculation window, no compensation
    isa_adder #(.WIDTH(32), .NPATH(4), .SPEC(0), .COR(0), .RED(0)) u_isa_adder_c3 (
        .opnd_a(ta), .opnd_b(tb), .carry_in(tc), .sum_out(s3), .carry_out(c3));

    function automatic longint model(input longint a, input longint b, input bit cin,
                                     input int n, input int sp, input int cr, input int rd);
        int seg = 32 / n;
        longint m = (64'd1 << seg) - 1;
        longint s [8];
        bit     co [8];
        longint r = 0;
        for (int k = 0; k < n; k++) begin
            longint av = (a >> (k*seg)) & m;
            longint bv = (b >> (k*seg)) & m;
            longint g;
            longint t;
            if (k == 0) g = cin;
            else if (sp == 0) g = 0;
            else begin
                longint wm = (64'd1 << sp) - 1;
                longint wa = (a >> (k*seg - sp)) & wm;
                longint wb = (b >> (k*seg - sp)) & wm;
                g = ((wa + wb) >> sp) & 1;
            end
            t = av + bv + g;
            s[k] = t & m;
            co[k] = t[seg];
            if (k > 0 && co[k-1] && g == 0) begin
                longint cm = (64'd1 << cr) - 1;
                if (cr > 0 && (s[k] & cm) != cm) s[k] = s[k] + 1;
                else s[k-1] = s[k-1] | (m & ~(m >> rd));
            end
        end
        for (int k = 0; k < n; k++) r = r | (s[k] << (k*seg));
        if (co[n-1]) r = r | (64'd1 << 32);
        return r;
    endfunction

    function automatic bit decided(input longint a, input longint b, input int n, input int sp);
        int seg = 32 / n;
        bit d = (sp > 0);
        for (int k = 1; k < n; k++) begin
            bit allp = 1;
            for (int i = 1; i <= sp; i++) if (a[k*seg-i] == b[k*seg-i]) allp = 0;
            if (allp) d = 0;
        end
        return d;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        ta = a; tb = b; tc = c;
        @(posedge clk);
        #1;
    endtask

    function automatic longint got(input logic cc, input logic [31:0] ss);
        return {31'd0, cc, ss};
    endfunction

    task automatic full_check(input logic [31:0] a, input logic [31:0] b, input logic c);
        longint ex = longint'(a) + longint'(b) + longint'(c);
        apply(a, b, c);
        chk("R2 model cfg1", got(c1, s1), model(a, b, c, 4, 2, 3, 2));
        chk("R2 model cfg2", got(c2, s2), model(a, b, c, 2, 1, 2, 4));
        chk("R8 model cfg3", got(c3, s3), model(a, b, c, 4, 0, 0, 0));
        chk("R1 low bits cfg1", longint'(s1 & 32'h3F), ex & 64'h3F);
        chk("R1 low bits cfg2", longint'(s2 & 32'h0FFF), ex & 64'h0FFF);
        if (decided(a, b, 4, 2)) chk("R3 exact cfg1", got(c1, s1), ex);
        if (decided(a, b, 2, 1)) chk("R3 exact cfg2", got(c2, s2), ex);
        if (b == 0 && !c) chk("R7 zero addend", got(c1, s1), longint'(a));
    endtask

    initial begin
        ta = '0; tb = '0; tc = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // zero operands after reset
        apply(32'h0, 32'h0, 1'b0);
        chk("R7 zero after reset", got(c1, s1), 64'h0);
        // correction of a missed carry
        apply(32'h000000FF, 32'h1, 1'b0);
        chk("R4 correction cfg1", got(c1, s1), 64'h100);
        chk("R8 dropped carry cfg3", got(c3, s3), 64'h0);
        // reduction when correction would overflow
        apply(32'h000007FF, 32'h1, 1'b0);
        chk("R5 reduction cfg1", got(c1, s1), 64'h7C0);
        chk("R8 no reduction cfg3", got(c3, s3), 64'h700);
        // carry-out taken from top local segment
        apply(32'hFFFFFFFF, 32'h1, 1'b0);
        chk("R6 cout kept local cfg1", got(c1, s1), 64'h0FFFFFFC0);
        apply(32'h80000000, 32'h80000000, 1'b0);
        chk("R6 R3 cout decided cfg1", got(c1, s1), 64'h100000000);
        // guess 1 from a generate inside the window
        apply(32'h000000C0, 32'h00000040, 1'b0);
        chk("R2 generate guess cfg1", got(c1, s1), 64'h100);
        // config 2 correction and reduction
        apply(32'h0000FFFF, 32'h1, 1'b0);
        chk("R4 correction cfg2", got(c2, s2), 64'h10000);
        apply(32'h0003FFFF, 32'h1, 1'b0);
        chk("R5 reduction cfg2", got(c2, s2), 64'h3F000);
        apply(32'h12345678, 32'h0, 1'b0);
        chk("R7 identity cfg1", got(c1, s1), 64'h12345678);
        // mixed random and propagate-heavy vectors
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b;
            unique case (i % 3)
                0: b = $urandom;
                1: b = ~a ^ (32'h1 << ($urandom % 32));
                default: b = (i % 6 == 2) ? 32'h0 : ~a;
            endcase
            full_check(a, b, 1'(($urandom % 2)));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule